// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the single step a processor core takes when it enters an exception or an interrupt handler. The core presents a request strobe, together with its current status word, program counter, stack register, vector base and delay-slot flag. With these come any pending exception code, any hardware interrupt request, and the interrupt controller's answer to the mask the block derives from the status word. In that cycle the block decides whether an event is accepted. If it is, the block saves the status word, the program counter and the stack register into shadow registers. It then raises the block, privilege and bank bits, picks the handler address from the event class, and records the event code in the exception or interrupt event register.

Exceptions take precedence over interrupts. While the block bit is set, an exception other than the one exempt code is turned into a reset entry. Interrupts are refused in that state unless the core is waking from a halt. If an event lands on a branch delay slot, the saved PC is rewound so that the branch runs again. A trap instruction saves the address that follows it.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are pending in the same request, only the exception is taken: the exception event register takes the code and the interrupt event register keeps its value.
- R2: With status bit 28 (block) set, an exception code other than 0x1E0 is taken as code 0x000 with the reset handler; code 0x1E0 is taken unchanged.
- R3: With status bit 28 set, an interrupt is refused unless the wake flag is set (set by a pulse on `haltWake`). Any request that proceeds under bit 28 clears the wake flag.
- R4: `icMask` equals status bits [7:4]. An interrupt is taken only if `icVecValid` is high. Otherwise `taken` stays low and every output register keeps its value.
- R5: On entry, `ssr` takes the status word, `sgr` takes R15 and `spc` takes the PC. The new status word is the old one with bits 28, 29 and 30 set.
- R6: If `dsActive` is high on entry, `spc` is the PC minus 2 and `dsClear` pulses with `taken`.
- R7: Codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits [7:4] to 0xF and jump to 0xA0000000.
- R8: Codes 0x040 and 0x060 jump to VBR+0x400.
- R9: Code 0x160 saves PC+2 in `spc` (net PC when combined with a delay slot) and jumps to VBR+0x100. Every other exception code also jumps to VBR+0x100.
- R10: A taken interrupt writes the controller's vector into `intevt`, leaves `expevt` unchanged and jumps to VBR+0x600.
- R11: Synchronous reset clears `expevt`, `intevt`, `ssr`, `spc`, `sgr`, `srOut`, `pcOut`, `taken`, `dsClear` and the wake flag.
- R12: Without `evtValid`, no state changes and `taken` stays low. All outputs are registered and change on the edge that samples `evtValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | Request one entry step this cycle |
| excPending | input | 1 | An exception is pending |
| excCode | input | 12 | Pending exception code |
| irqReq | input | 1 | Hardware interrupt request |
| haltWake | input | 1 | Pulse: core is waking from halt |
| srIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| r15In | input | 32 | Current stack register |
| vbrIn | input | 32 | Vector base |
| dsActive | input | 1 | Current instruction sits in a delay slot |
| icMask | output | 4 | Interrupt mask handed to the controller |
| icVecValid | input | 1 | Controller has a vector above the mask |
| icVector | input | 12 | Controller's interrupt vector code |
| taken | output | 1 | Pulse: an event was entered |
| dsClear | output | 1 | Pulse: clear the core's delay-slot flags |
| srOut | output | 32 | New status word |
| pcOut | output | 32 | Handler address |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved PC |
| sgr | output | 32 | Saved stack register |
| expevt | output | 12 | Last exception code |
| intevt | output | 12 | Last interrupt vector |

## Verification
Two functions can fall in the same cycle. The first pair is exception priority and interrupt acceptance, which the bench provokes by raising `excPending` and `irqReq` together with a valid vector. It judges the result by `expevt` taking the code while `intevt` keeps its prior value and `pcOut` points at the exception handler. The second pair is the delay-slot rewind and the trap adjustment. The bench hits both with one request and expects `spc` to equal the unmodified PC.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 12;
  localparam int WORD_W = 32;

  localparam int BIT_BL = 28;
  localparam int BIT_RB = 29;
  localparam int BIT_MD = 30;
  localparam int BIT_FD = 15;
  localparam int MASK_LO = 4;

  localparam logic [CODE_W-1:0] CODE_RESET  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_EXEMPT = 12'h1E0;
  localparam logic [CODE_W-1:0] CODE_TRAP   = 12'h160;

  localparam logic [WORD_W-1:0] RESET_PC = 32'hA000_0000;
  localparam logic [WORD_W-1:0] OFS_TLB  = 32'h0000_0400;
  localparam logic [WORD_W-1:0] OFS_GEN  = 32'h0000_0100;
  localparam logic [WORD_W-1:0] OFS_IRQ  = 32'h0000_0600;

  typedef enum logic [1:0] {VEC_RESET, VEC_TLB, VEC_GEN, VEC_IRQ} vecSel_e;

  typedef struct packed {
    logic              takeExp;
    logic              takeIrq;
    logic              dsRewind;
    logic              trapAdj;
    vecSel_e           vecSel;
    logic [CODE_W-1:0] code;
  } entryCtl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evtValid,
  input  logic              excPending,
  input  logic [CODE_W-1:0] excCode,
  input  logic              irqReq,
  input  logic              haltWake,
  input  logic              blBit,
  input  logic              dsActive,
  input  logic              icVecValid,
  output entryCtl_t         ctl
);
  logic wakeFlag;
  logic doExp, doIrq, irqBlocked, clrWake;
  logic [CODE_W-1:0] effCode;

  always_comb begin
    doExp      = excPending;
    doIrq      = irqReq && !excPending;
    irqBlocked = blBit && doIrq && !wakeFlag;
    clrWake    = evtValid && blBit && (doExp || doIrq) && !irqBlocked;
    effCode    = (blBit && excCode != CODE_EXEMPT) ? CODE_RESET : excCode;

    ctl.takeExp  = evtValid && doExp;
    ctl.takeIrq  = evtValid && doIrq && !irqBlocked && icVecValid;
    ctl.dsRewind = dsActive;
    ctl.trapAdj  = ctl.takeExp && (effCode == CODE_TRAP);
    ctl.code     = effCode;

    if (doIrq) ctl.vecSel = VEC_IRQ;
    else begin
      case (effCode)
        12'h000, 12'h020, 12'h140: ctl.vecSel = VEC_RESET;
        12'h040, 12'h060:          ctl.vecSel = VEC_TLB;
        default:                   ctl.vecSel = VEC_GEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            wakeFlag <= 1'b0;
    else if (clrWake)   wakeFlag <= 1'b0;
    else if (haltWake)  wakeFlag <= 1'b1;
  end

  assert_blocked_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (evtValid && blBit && irqReq && !excPending && !wakeFlag) |-> !ctl.takeIrq);

  assert_exc_wins_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.takeExp, ctl.takeIrq}));
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  entryCtl_t         ctl,
  input  logic [WORD_W-1:0] srIn,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] r15In,
  input  logic [WORD_W-1:0] vbrIn,
  input  logic [CODE_W-1:0] icVector,
  output logic              taken,
  output logic              dsClear,
  output logic [WORD_W-1:0] srOut,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] ssr,
  output logic [WORD_W-1:0] spc,
  output logic [WORD_W-1:0] sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  logic take;
  logic [WORD_W-1:0] srNew, target, savedPc;
  logic pastOk, wasResetEntry;

  always_comb begin
    take  = ctl.takeExp || ctl.takeIrq;
    srNew = srIn;
    srNew[BIT_BL] = 1'b1;
    srNew[BIT_MD] = 1'b1;
    srNew[BIT_RB] = 1'b1;
    savedPc = pcIn;
    if (ctl.dsRewind) savedPc = savedPc - 32'd2;
    if (ctl.trapAdj)  savedPc = savedPc + 32'd2;
    case (ctl.vecSel)
      VEC_RESET: begin
        target = RESET_PC;
        srNew[BIT_FD] = 1'b0;
        srNew[MASK_LO+3:MASK_LO] = 4'hF;
      end
      VEC_TLB: target = vbrIn + OFS_TLB;
      VEC_GEN: target = vbrIn + OFS_GEN;
      default: target = vbrIn + OFS_IRQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken   <= 1'b0;
      dsClear <= 1'b0;
      srOut   <= '0;
      pcOut   <= '0;
      ssr     <= '0;
      spc     <= '0;
      sgr     <= '0;
      expevt  <= '0;
      intevt  <= '0;
      pastOk  <= 1'b0;
      wasResetEntry <= 1'b0;
    end else begin
      pastOk  <= 1'b1;
      taken   <= take;
      dsClear <= take && ctl.dsRewind;
      wasResetEntry <= ctl.takeExp && ctl.vecSel == VEC_RESET;
      if (take) begin
        ssr   <= srIn;
        spc   <= savedPc;
        sgr   <= r15In;
        srOut <= srNew;
        pcOut <= target;
      end
      if (ctl.takeExp) expevt <= ctl.code;
      if (ctl.takeIrq) intevt <= icVector;
    end
  end

  assert_status_bits_R5: assert property (@(posedge clk) disable iff (rst)
    taken |-> (srOut[BIT_BL] && srOut[BIT_MD] && srOut[BIT_RB]));

  assert_reset_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (pastOk && wasResetEntry) |->
      (pcOut == RESET_PC && srOut[MASK_LO+3:MASK_LO] == 4'hF && !srOut[BIT_FD]));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !take) |=> ($stable(ssr) && $stable(spc) && $stable(pcOut)));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evtValid,
  input  logic              excPending,
  input  logic [CODE_W-1:0] excCode,
  input  logic              irqReq,
  input  logic              haltWake,
  input  logic [WORD_W-1:0] srIn,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] r15In,
  input  logic [WORD_W-1:0] vbrIn,
  input  logic              dsActive,
  output logic [3:0]        icMask,
  input  logic              icVecValid,
  input  logic [CODE_W-1:0] icVector,
  output logic              taken,
  output logic              dsClear,
  output logic [WORD_W-1:0] srOut,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] ssr,
  output logic [WORD_W-1:0] spc,
  output logic [WORD_W-1:0] sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  entryCtl_t ctl;

  assign icMask = srIn[MASK_LO+3:MASK_LO];

  exc_entry_ctrl u_ctrl (
    .clk(clk), .rst(rst), .evtValid(evtValid), .excPending(excPending),
    .excCode(excCode), .irqReq(irqReq), .haltWake(haltWake),
    .blBit(srIn[BIT_BL]), .dsActive(dsActive), .icVecValid(icVecValid),
    .ctl(ctl)
  );

  exc_entry_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .srIn(srIn), .pcIn(pcIn),
    .r15In(r15In), .vbrIn(vbrIn), .icVector(icVector),
    .taken(taken), .dsClear(dsClear), .srOut(srOut), .pcOut(pcOut),
    .ssr(ssr), .spc(spc), .sgr(sgr), .expevt(expevt), .intevt(intevt)
  );
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic clk = 1'b0;
  logic rst;
  logic evtValid, excPending, irqReq, haltWake, dsActive, icVecValid;
  logic [11:0] excCode, icVector;
  logic [31:0] srIn, pcIn, r15In, vbrIn;
  logic [3:0] icMask;
  logic taken, dsClear;
  logic [31:0] srOut, pcOut, ssr, spc, sgr;
  logic [11:0] expevt, intevt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] SR_ENTRY = 32'h7000_0000;

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .excPending(excPending),
    .excCode(excCode), .irqReq(irqReq), .haltWake(haltWake), .srIn(srIn),
    .pcIn(pcIn), .r15In(r15In), .vbrIn(vbrIn), .dsActive(dsActive),
    .icMask(icMask), .icVecValid(icVecValid), .icVector(icVector),
    .taken(taken), .dsClear(dsClear), .srOut(srOut), .pcOut(pcOut),
    .ssr(ssr), .spc(spc), .sgr(sgr), .expevt(expevt), .intevt(intevt)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    evtValid = 0; excPending = 0; irqReq = 0; haltWake = 0; dsActive = 0;
    icVecValid = 0; excCode = 0; icVector = 0;
  endtask

  // one request: drive at negedge, sampled at posedge, check at next negedge
  task automatic step(logic exc, logic [11:0] code, logic irq, logic vv,
                      logic [11:0] vec, logic ds, logic [31:0] sr, logic [31:0] pc);
    @(negedge clk);
    evtValid = 1; excPending = exc; excCode = code; irqReq = irq;
    icVecValid = vv; icVector = vec; dsActive = ds; srIn = sr; pcIn = pc;
    r15In = pc ^ 32'h5A5A_0000; vbrIn = VBR;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R11 taken", {31'b0, taken}, 0);
    chk("R11 expevt", {20'b0, expevt}, 0);
    chk("R11 intevt", {20'b0, intevt}, 0);
    chk("R11 spc", spc, 0);
    chk("R11 ssr", ssr, 0);
  endtask

  task automatic t_no_valid();
    @(negedge clk);
    excPending = 1; excCode = 12'h180; srIn = 32'h0; pcIn = 32'h100;
    @(negedge clk);
    chk("R12 taken", {31'b0, taken}, 0);
    chk("R12 expevt", {20'b0, expevt}, 0);
    idle();
  endtask

  task automatic t_priority();
    step(1, 12'h180, 1, 1, 12'h320, 0, 32'h0000_0030, 32'h0000_1000);
    chk("R1 taken", {31'b0, taken}, 1);
    chk("R1 expevt", {20'b0, expevt}, 32'h180);
    chk("R1 intevt", {20'b0, intevt}, 0);
    chk("R9 pc", pcOut, VBR + 32'h100);
    chk("R5 ssr", ssr, 32'h0000_0030);
    chk("R5 spc", spc, 32'h0000_1000);
    chk("R5 sgr", sgr, 32'h0000_1000 ^ 32'h5A5A_0000);
    chk("R5 sr", srOut, 32'h7000_0030);
    chk("R6 no dsClear", {31'b0, dsClear}, 0);
  endtask

  task automatic t_tlb();
    step(1, 12'h040, 0, 0, 0, 0, 32'h0, 32'h2000);
    chk("R8 0x040 pc", pcOut, VBR + 32'h400);
    step(1, 12'h060, 0, 0, 0, 0, 32'h0, 32'h2000);
    chk("R8 0x060 pc", pcOut, VBR + 32'h400);
  endtask

  task automatic t_trap_ds();
    step(1, 12'h160, 0, 0, 0, 0, 32'h0, 32'h2000);
    chk("R9 trap spc", spc, 32'h2002);
    chk("R9 trap pc", pcOut, VBR + 32'h100);
    step(1, 12'h180, 0, 0, 0, 1, 32'h0, 32'h3000);
    chk("R6 ds spc", spc, 32'h2FFE);
    chk("R6 dsClear", {31'b0, dsClear}, 1);
    step(1, 12'h160, 0, 0, 0, 1, 32'h0, 32'h4000);
    chk("R6 R9 ds+trap spc", spc, 32'h4000);
  endtask

  task automatic t_reset_class();
    step(1, 12'h020, 0, 0, 0, 0, 32'h0000_8030, 32'h5000);
    chk("R7 0x020 pc", pcOut, 32'hA000_0000);
    chk("R7 0x020 sr", srOut, SR_ENTRY | 32'h0000_00F0);
    step(1, 12'h140, 0, 0, 0, 0, 32'h0000_8000, 32'h5000);
    chk("R7 0x140 pc", pcOut, 32'hA000_0000);
  endtask

  task automatic t_block();
    step(1, 12'h180, 0, 0, 0, 0, 32'h1000_0000, 32'h6000);
    chk("R2 masked expevt", {20'b0, expevt}, 0);
    chk("R2 masked pc", pcOut, 32'hA000_0000);
    step(1, 12'h1E0, 0, 0, 0, 0, 32'h1000_0000, 32'h6000);
    chk("R2 exempt expevt", {20'b0, expevt}, 32'h1E0);
    chk("R2 exempt pc", pcOut, VBR + 32'h100);
  endtask

  task automatic t_irq();
    logic [31:0] keepPc;
    @(negedge clk);
    srIn = 32'h0000_0050;
    #1 chk("R4 icMask", {28'b0, icMask}, 5);
    step(0, 0, 1, 1, 12'h320, 0, 32'h0000_0050, 32'h7000);
    chk("R10 taken", {31'b0, taken}, 1);
    chk("R10 intevt", {20'b0, intevt}, 32'h320);
    chk("R10 expevt kept", {20'b0, expevt}, 32'h1E0);
    chk("R10 pc", pcOut, VBR + 32'h600);
    keepPc = pcOut;
    step(0, 0, 1, 0, 12'h3C0, 0, 32'h0000_0050, 32'h7100);
    chk("R4 no vector taken", {31'b0, taken}, 0);
    chk("R4 no vector intevt", {20'b0, intevt}, 32'h320);
    chk("R4 no vector spc", spc, 32'h7000);
    chk("R4 no vector pc", pcOut, keepPc);
  endtask

  task automatic t_wake();
    step(0, 0, 1, 1, 12'h400, 0, 32'h1000_0000, 32'h8000);
    chk("R3 blocked taken", {31'b0, taken}, 0);
    chk("R3 blocked intevt", {20'b0, intevt}, 32'h320);
    @(negedge clk); haltWake = 1;
    @(negedge clk); haltWake = 0;
    step(0, 0, 1, 1, 12'h400, 0, 32'h1000_0000, 32'h8000);
    chk("R3 wake taken", {31'b0, taken}, 1);
    chk("R3 wake intevt", {20'b0, intevt}, 32'h400);
    step(0, 0, 1, 1, 12'h420, 0, 32'h1000_0000, 32'h8100);
    chk("R3 wake consumed", {31'b0, taken}, 0);
    chk("R3 consumed intevt", {20'b0, intevt}, 32'h400);
  endtask

  initial begin
    idle();
    srIn = 0; pcIn = 0; r15In = 0; vbrIn = VBR;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_no_valid();
    t_priority();
    t_tlb();
    t_trap_ds();
    t_reset_class();
    t_block();
    t_irq();
    t_wake();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule